// File: doc/BRIEF.md
# Protection Map Configuration Register File

This block is the software-visible half of a memory security gate. It holds a packed map with one bit per memory block, where a set bit marks that block as reachable by non-secure masters only and a clear bit marks it as secure-only. It also holds a few control bits, an interrupt status with its enable, set and clear registers, and two registers that record the first blocked access. Twelve read-only identification words sit at the top of the 4 KiB register window. The map, the error-response control bit, the interrupt enable and the interrupt line go to the filtering gate. The gate sends back a violation event that carries the offending address, the master number, the access security and the map bit it hit.

Software reaches the map one 32-bit word at a time. It first writes a word pointer and then reads or writes a data window. When stepping is on, each full-word access to the window moves the pointer forward. It wraps at the last word so that a whole map can be streamed. A sticky lock bit freezes the control word, the map and the interrupt enable until the next reset. Only secure masters may touch configuration; a non-secure master sees only the identification words.

The bus is a one-cycle register port. The word address, write flag, byte strobes, write data and secure flag are presented together with a valid. Read data appears on the next cycle.

Top module: `secmap_cfg_regs`

## Requirements
- R1: After reset, control reads 0x0000_0100 (stepping on, lock and error-response off), the interrupt enable reads 1, and the pointer, status, both info registers and every map word read 0.
- R2: An access with the secure flag low to any byte offset below 0xFD0 returns read data 0 and changes no state. Identification word n (n = 0..11, byte offset 0xFD0 + 4n) reads 0x3C XOR (0x11·n) in bits 7:0 and zero above, for secure and non-secure masters alike.
- R3: When stepping (control bit 8) is set, a full-word access (strobe 0xF) to the map data window (offset 0x1C), read or accepted write, moves the pointer to (pointer + 1) mod MAP_WORDS. An access with any other strobe leaves the pointer where it was.
- R4: A write to the pointer register (offset 0x18) stores the 32-bit written value mod MAP_WORDS. Reading it returns the pointer.
- R5: While control bit 31 (lock) is set, writes to control (0x00), map data (0x1C) and interrupt enable (0x28) have no effect, and a full-word map data write does not step the pointer. Only reset clears the lock.
- R6: A write with a partial strobe to control, pointer or map data keeps the unstrobed bytes of the current value. For every other register, the unstrobed bytes count as zero. The written map data lands in word `pointer`, and that word drives map_o bits [32·pointer+31 : 32·pointer].
- R7: A read returns the register value with every unstrobed byte lane forced to zero and the strobed lanes left in place.
- R8: Control keeps only bit 4 (error response, driven on sec_resp_o), bit 8 and bit 31, and the other bits read 0. Offset 0x10 reads MAP_WORDS−1, and offset 0x14 reads BLK_LOG2−5.
- R9: Writing a value with bit 0 set to offset 0x34 sets the interrupt status (offset 0x20, bit 0), and writing one with bit 0 set to offset 0x24 clears it. Values with bit 0 clear do nothing. Both offsets read 0. Writes to identification words and to undefined offsets are ignored, and undefined offsets read 0.
- R10: A violation event while the status is 0 sets the status and records the address in info1 (0x2C). It records {cfg_ns at bit 17, nonsec at bit 16, master at bits 15:0} in info2 (0x30). A violation while the status is already 1 changes neither info register.
- R11: A violation in the same cycle as a status-clear write leaves the status at 1.
- R12: irq_o is high exactly when the status is 1 and the interrupt enable (offset 0x28, bit 0) is 1. irq_en_o follows that enable bit.
- R13: Read data for an accepted read appears on rsp_rdata_o in the cycle after the request. In every other cycle, rsp_rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register access this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_waddr_i | input | 10 | Word address (byte offset / 4) |
| req_strb_i | input | 4 | Byte lane strobes |
| req_wdata_i | input | 32 | Write data |
| req_secure_i | input | 1 | Access comes from a secure master |
| rsp_rdata_o | output | 32 | Read data, one cycle after the request |
| viol_valid_i | input | 1 | Gate reports a blocked access |
| viol_addr_i | input | 32 | Address of the blocked access |
| viol_master_i | input | 16 | Master number of the blocked access |
| viol_nonsec_i | input | 1 | Blocked access was non-secure |
| viol_cfg_ns_i | input | 1 | Map bit of the block that was hit |
| map_o | output | 32·MAP_WORDS | Packed block security map |
| sec_resp_o | output | 1 | Blocked accesses get an error response |
| irq_en_o | output | 1 | Interrupt enable |
| irq_o | output | 1 | Violation interrupt |

## Verification
The bench aims at the pointer wrap from the last map word to word 0. A design that wraps at the next power of two would write past the map or leave words unreachable. It checks that partial-strobe writes to the pointer are merged before the modulo: the merged value 0x302 lands on 0, where a zero-filled 0x300 would land on 3. It also checks that sub-word writes to the enable clear it, since the missing low lane counts as zero. Lockdown is exercised on all three protected registers, and the bench confirms that the pointer still moves and a fresh reset is the only release; a lock that could be cleared or skipped would let software rewrite the map. The bench drives a violation into the same cycle as a clear and into a set status. A wrong priority would lose the interrupt, and unguarded capture would overwrite the first recorded fault.

// File: rtl/secmap_pkg.sv
package secmap_pkg;

    // Word offsets (byte offset / 4) inside the 4 KiB window
    localparam logic [9:0] WO_CTRL  = 10'h000;
    localparam logic [9:0] WO_COUNT = 10'h004;
    localparam logic [9:0] WO_BCFG  = 10'h005;
    localparam logic [9:0] WO_PTR   = 10'h006;
    localparam logic [9:0] WO_DATA  = 10'h007;
    localparam logic [9:0] WO_STAT  = 10'h008;
    localparam logic [9:0] WO_CLR   = 10'h009;
    localparam logic [9:0] WO_EN    = 10'h00A;
    localparam logic [9:0] WO_INFO1 = 10'h00B;
    localparam logic [9:0] WO_INFO2 = 10'h00C;
    localparam logic [9:0] WO_SET   = 10'h00D;
    localparam logic [9:0] WO_ID_LO = 10'h3F4;

    // Control bit positions
    localparam int unsigned CB_RESP = 4;
    localparam int unsigned CB_STEP = 8;
    localparam int unsigned CB_LOCK = 31;

    typedef struct packed {
        logic lock;
        logic step;
        logic resp;
    } ctrl_t;

    typedef struct packed {
        logic       ctrl;
        logic       count;
        logic       bcfg;
        logic       ptr;
        logic       data;
        logic       stat;
        logic       clr;
        logic       en;
        logic       info1;
        logic       info2;
        logic       set;
        logic       id;
        logic [3:0] id_num;
    } sel_t;

    function automatic logic [31:0] ctrl_word(input ctrl_t c);
        logic [31:0] w;
        w          = '0;
        w[CB_RESP] = c.resp;
        w[CB_STEP] = c.step;
        w[CB_LOCK] = c.lock;
        return w;
    endfunction

    function automatic logic [31:0] lane_mask(input logic [3:0] s);
        return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    endfunction

    function automatic logic [31:0] id_word(input logic [3:0] n);
        return {24'h0, 8'h3C ^ (8'h11 * {4'h0, n})};
    endfunction

endpackage

// File: rtl/secmap_decode.sv
module secmap_decode
    import secmap_pkg::*;
(
    input  logic       valid_i,
    input  logic [9:0] waddr_i,
    input  logic       secure_i,
    output sel_t       sel_o
);

    logic allowed;

    always_comb begin
        allowed = valid_i && (secure_i || (waddr_i >= WO_ID_LO));
        sel_o        = '0;
        sel_o.id_num = 4'(waddr_i - WO_ID_LO);
        if (allowed) begin
            case (waddr_i)
                WO_CTRL:  sel_o.ctrl  = 1'b1;
                WO_COUNT: sel_o.count = 1'b1;
                WO_BCFG:  sel_o.bcfg  = 1'b1;
                WO_PTR:   sel_o.ptr   = 1'b1;
                WO_DATA:  sel_o.data  = 1'b1;
                WO_STAT:  sel_o.stat  = 1'b1;
                WO_CLR:   sel_o.clr   = 1'b1;
                WO_EN:    sel_o.en    = 1'b1;
                WO_INFO1: sel_o.info1 = 1'b1;
                WO_INFO2: sel_o.info2 = 1'b1;
                WO_SET:   sel_o.set   = 1'b1;
                default:  sel_o.id    = (waddr_i >= WO_ID_LO);
            endcase
        end
    end

endmodule

// File: rtl/secmap_map_store.sv
module secmap_map_store #(
    parameter int unsigned WORDS = 5,
    parameter int unsigned IDX_W = 3
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  logic [IDX_W-1:0]     wr_idx_i,
    input  logic [31:0]          wr_data_i,
    input  logic [IDX_W-1:0]     rd_idx_i,
    output logic [31:0]          rd_data_o,
    output logic [WORDS*32-1:0]  map_o
);

    logic [31:0] word_q [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [31:0] word_d;

        always_comb begin
            word_d = word_q[g];
            if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                word_d = wr_data_i;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                word_q[g] <= '0;
            end else begin
                word_q[g] <= word_d;
            end
        end

        assign map_o[g*32 +: 32] = word_q[g];
    end

    assign rd_data_o = word_q[rd_idx_i];

endmodule

// File: rtl/secmap_irq_ctl.sv
module secmap_irq_ctl (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        set_req_i,
    input  logic        clr_req_i,
    input  logic        viol_valid_i,
    input  logic [31:0] viol_addr_i,
    input  logic [15:0] viol_master_i,
    input  logic        viol_nonsec_i,
    input  logic        viol_cfg_ns_i,
    output logic        stat_o,
    output logic [31:0] info1_o,
    output logic [31:0] info2_o
);

    typedef struct packed {
        logic        stat;
        logic [31:0] info1;
        logic [17:0] info2;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_req_i) begin
            st_d.stat = 1'b0;
        end
        if (set_req_i) begin
            st_d.stat = 1'b1;
        end
        // a violation outranks a clear in the same cycle
        if (viol_valid_i) begin
            st_d.stat = 1'b1;
            if (!st_q.stat) begin
                st_d.info1 = viol_addr_i;
                st_d.info2 = {viol_cfg_ns_i, viol_nonsec_i, viol_master_i};
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o  = st_q.stat;
    assign info1_o = st_q.info1;
    assign info2_o = {14'h0, st_q.info2};

endmodule

// File: rtl/secmap_cfg_regs.sv
module secmap_cfg_regs
    import secmap_pkg::*;
#(
    parameter int unsigned MAP_WORDS = 5,
    parameter int unsigned BLK_LOG2  = 12
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     req_valid_i,
    input  logic                     req_write_i,
    input  logic [9:0]               req_waddr_i,
    input  logic [3:0]               req_strb_i,
    input  logic [31:0]              req_wdata_i,
    input  logic                     req_secure_i,
    output logic [31:0]              rsp_rdata_o,
    input  logic                     viol_valid_i,
    input  logic [31:0]              viol_addr_i,
    input  logic [15:0]              viol_master_i,
    input  logic                     viol_nonsec_i,
    input  logic                     viol_cfg_ns_i,
    output logic [MAP_WORDS*32-1:0]  map_o,
    output logic                     sec_resp_o,
    output logic                     irq_en_o,
    output logic                     irq_o
);

    localparam int unsigned IDX_W     = (MAP_WORDS > 1) ? $clog2(MAP_WORDS) : 1;
    localparam logic [31:0] COUNT_VAL = 32'(MAP_WORDS - 1);
    localparam logic [31:0] BCFG_VAL  = 32'(BLK_LOG2 - 5);
    localparam logic [31:0] WORDS_32  = 32'(MAP_WORDS);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [IDX_W-1:0]  idx;
        logic              en;
        logic [31:0]       rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    sel_t        sel;
    logic [31:0] map_rd;
    logic        stat;
    logic [31:0] info1;
    logic [31:0] info2;

    logic [31:0]      mask;
    logic [31:0]      base;
    logic [31:0]      wval;
    logic [31:0]      rword;
    logic [IDX_W-1:0] idx_next;
    logic             full;
    logic             map_we;
    logic             set_req;
    logic             clr_req;

    // signals watched by the bound checker
    logic             lock_q;
    logic [IDX_W-1:0] idx_q;

    secmap_decode u_decode (
        .valid_i  (req_valid_i),
        .waddr_i  (req_waddr_i),
        .secure_i (req_secure_i),
        .sel_o    (sel)
    );

    secmap_map_store #(
        .WORDS (MAP_WORDS),
        .IDX_W (IDX_W)
    ) u_map (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (map_we),
        .wr_idx_i  (st_q.idx),
        .wr_data_i (wval),
        .rd_idx_i  (st_q.idx),
        .rd_data_o (map_rd),
        .map_o     (map_o)
    );

    secmap_irq_ctl u_irq (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .set_req_i     (set_req),
        .clr_req_i     (clr_req),
        .viol_valid_i  (viol_valid_i),
        .viol_addr_i   (viol_addr_i),
        .viol_master_i (viol_master_i),
        .viol_nonsec_i (viol_nonsec_i),
        .viol_cfg_ns_i (viol_cfg_ns_i),
        .stat_o        (stat),
        .info1_o       (info1),
        .info2_o       (info2)
    );

    always_comb begin
        mask = lane_mask(req_strb_i);
        full = (req_strb_i == 4'hF);

        if (sel.ctrl) begin
            base = ctrl_word(st_q.ctrl);
        end else if (sel.ptr) begin
            base = 32'(st_q.idx);
        end else if (sel.data) begin
            base = map_rd;
        end else begin
            base = '0;
        end
        wval = (base & ~mask) | (req_wdata_i & mask);

        idx_next = (st_q.idx == IDX_W'(MAP_WORDS - 1)) ? '0 : st_q.idx + IDX_W'(1);

        if (sel.ctrl) begin
            rword = ctrl_word(st_q.ctrl);
        end else if (sel.count) begin
            rword = COUNT_VAL;
        end else if (sel.bcfg) begin
            rword = BCFG_VAL;
        end else if (sel.ptr) begin
            rword = 32'(st_q.idx);
        end else if (sel.data) begin
            rword = map_rd;
        end else if (sel.stat) begin
            rword = {31'h0, stat};
        end else if (sel.en) begin
            rword = {31'h0, st_q.en};
        end else if (sel.info1) begin
            rword = info1;
        end else if (sel.info2) begin
            rword = info2;
        end else if (sel.id) begin
            rword = id_word(sel.id_num);
        end else begin
            rword = '0;
        end

        st_d       = st_q;
        st_d.rdata = '0;
        map_we     = 1'b0;
        set_req    = 1'b0;
        clr_req    = 1'b0;

        if (req_write_i) begin
            if (sel.ctrl && !st_q.ctrl.lock) begin
                st_d.ctrl.lock = wval[CB_LOCK];
                st_d.ctrl.step = wval[CB_STEP];
                st_d.ctrl.resp = wval[CB_RESP];
            end
            if (sel.ptr) begin
                st_d.idx = IDX_W'(wval % WORDS_32);
            end
            if (sel.en && !st_q.ctrl.lock) begin
                st_d.en = wval[0];
            end
            map_we  = sel.data && !st_q.ctrl.lock;
            set_req = sel.set && wval[0];
            clr_req = sel.clr && wval[0];
            if (map_we && full && st_q.ctrl.step) begin
                st_d.idx = idx_next;
            end
        end else begin
            st_d.rdata = rword & mask;
            if (sel.data && full && st_q.ctrl.step) begin
                st_d.idx = idx_next;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q           <= '0;
            st_q.ctrl.step <= 1'b1;
            st_q.en        <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_rdata_o = st_q.rdata;
    assign sec_resp_o  = st_q.ctrl.resp;
    assign irq_en_o    = st_q.en;
    assign irq_o       = stat & st_q.en;
    assign lock_q      = st_q.ctrl.lock;
    assign idx_q       = st_q.idx;

endmodule

// File: rtl/secmap_cfg_regs_chk.sv
module secmap_cfg_regs_chk #(
    parameter int unsigned MAP_WORDS = 5,
    parameter int unsigned IDX_W     = 3
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     req_valid_i,
    input logic                     req_write_i,
    input logic [9:0]               req_waddr_i,
    input logic [3:0]               req_strb_i,
    input logic                     req_secure_i,
    input logic [31:0]              rsp_rdata_o,
    input logic                     viol_valid_i,
    input logic [MAP_WORDS*32-1:0]  map_o,
    input logic                     lock_q,
    input logic [IDX_W-1:0]         idx_q,
    input logic                     stat_q,
    input logic [31:0]              info1_q
);

    assert_lock_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_q |=> lock_q);

    assert_map_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_q |=> $stable(map_o));

    assert_ns_reads_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !req_write_i && !req_secure_i && (req_waddr_i < 10'h3F4))
        |=> (rsp_rdata_o == 32'h0));

    assert_ptr_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        32'(idx_q) < MAP_WORDS);

    assert_subword_no_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_secure_i && (req_waddr_i == 10'h007) && (req_strb_i != 4'hF))
        |=> $stable(idx_q));

    assert_capture_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        viol_valid_i |=> stat_q);

    assert_info_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_q |=> $stable(info1_q));

    assert_idle_rdata_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> (rsp_rdata_o == 32'h0));

endmodule

bind secmap_cfg_regs secmap_cfg_regs_chk #(
    .MAP_WORDS (MAP_WORDS),
    .IDX_W     (IDX_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_write_i  (req_write_i),
    .req_waddr_i  (req_waddr_i),
    .req_strb_i   (req_strb_i),
    .req_secure_i (req_secure_i),
    .rsp_rdata_o  (rsp_rdata_o),
    .viol_valid_i (viol_valid_i),
    .map_o        (map_o),
    .lock_q       (lock_q),
    .idx_q        (idx_q),
    .stat_q       (stat),
    .info1_q      (info1)
);

// File: tb/secmap_cfg_regs_bench.sv
module secmap_cfg_regs_bench;

    localparam int NW = 5;

    localparam logic [9:0] A_CTRL  = 10'h000;
    localparam logic [9:0] A_COUNT = 10'h004;
    localparam logic [9:0] A_BCFG  = 10'h005;
    localparam logic [9:0] A_PTR   = 10'h006;
    localparam logic [9:0] A_DATA  = 10'h007;
    localparam logic [9:0] A_STAT  = 10'h008;
    localparam logic [9:0] A_CLR   = 10'h009;
    localparam logic [9:0] A_EN    = 10'h00A;
    localparam logic [9:0] A_INFO1 = 10'h00B;
    localparam logic [9:0] A_INFO2 = 10'h00C;
    localparam logic [9:0] A_SET   = 10'h00D;
    localparam logic [9:0] A_ID0   = 10'h3F4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [9:0]    req_waddr = '0;
    logic [3:0]    req_strb = '0;
    logic [31:0]   req_wdata = '0;
    logic          req_secure = 1'b0;
    logic [31:0]   rsp_rdata;
    logic          viol_valid = 1'b0;
    logic [31:0]   viol_addr = '0;
    logic [15:0]   viol_master = '0;
    logic          viol_nonsec = 1'b0;
    logic          viol_cfg_ns = 1'b0;
    logic [NW*32-1:0] map;
    logic          sec_resp;
    logic          irq_en;
    logic          irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    secmap_cfg_regs #(.MAP_WORDS(NW), .BLK_LOG2(12)) u_secmap_cfg_regs (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .req_valid_i   (req_valid),
        .req_write_i   (req_write),
        .req_waddr_i   (req_waddr),
        .req_strb_i    (req_strb),
        .req_wdata_i   (req_wdata),
        .req_secure_i  (req_secure),
        .rsp_rdata_o   (rsp_rdata),
        .viol_valid_i  (viol_valid),
        .viol_addr_i   (viol_addr),
        .viol_master_i (viol_master),
        .viol_nonsec_i (viol_nonsec),
        .viol_cfg_ns_i (viol_cfg_ns),
        .map_o         (map),
        .sec_resp_o    (sec_resp),
        .irq_en_o      (irq_en),
        .irq_o         (irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_ctrl;
    int          m_idx;
    bit          m_en;
    bit          m_stat;
    logic [31:0] m_info1;
    logic [31:0] m_info2;
    logic [31:0] m_map [NW];
    logic [31:0] m_rdata;

    function automatic logic [31:0] m_read(input int off);
        case (off)
            'h000: return m_ctrl;
            'h010: return 32'(NW - 1);
            'h014: return 32'd7;
            'h018: return 32'(m_idx);
            'h01C: return m_map[m_idx];
            'h020: return {31'h0, m_stat};
            'h028: return {31'h0, m_en};
            'h02C: return m_info1;
            'h030: return m_info2;
            default: begin
                if (off >= 'hFD0) return {24'h0, 8'h3C ^ 8'(((off - 'hFD0) / 4) * 17)};
                return 32'h0;
            end
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 32'h0000_0100; m_idx = 0; m_en = 1'b1; m_stat = 1'b0;
            m_info1 = '0; m_info2 = '0; m_rdata = '0;
            for (int i = 0; i < NW; i++) m_map[i] = '0;
        end else begin
            logic [31:0] mk, wv, bs, nrd;
            int off;
            bit old_stat, locked, stepping;
            nrd = '0;
            old_stat = m_stat;
            locked = m_ctrl[31];
            stepping = m_ctrl[8];
            if (req_valid) begin
                off = int'(req_waddr) * 4;
                mk = {{8{req_strb[3]}}, {8{req_strb[2]}}, {8{req_strb[1]}}, {8{req_strb[0]}}};
                if (req_secure || off >= 'hFD0) begin
                    if (req_write) begin
                        bs = (off == 0) ? m_ctrl : (off == 'h18) ? 32'(m_idx) :
                             (off == 'h1C) ? m_map[m_idx] : 32'h0;
                        wv = (bs & ~mk) | (req_wdata & mk);
                        case (off)
                            'h000: if (!locked) m_ctrl = wv & 32'h8000_0110;
                            'h018: m_idx = int'(wv % NW);
                            'h01C: if (!locked) begin
                                m_map[m_idx] = wv;
                                if (req_strb == 4'hF && stepping) m_idx = (m_idx + 1) % NW;
                            end
                            'h024: if (wv[0]) m_stat = 1'b0;
                            'h028: if (!locked) m_en = wv[0];
                            'h034: if (wv[0]) m_stat = 1'b1;
                            default: ;
                        endcase
                    end else begin
                        nrd = m_read(off) & mk;
                        if (off == 'h1C && req_strb == 4'hF && stepping) m_idx = (m_idx + 1) % NW;
                    end
                end
            end
            if (viol_valid) begin
                if (!old_stat) begin
                    m_info1 = viol_addr;
                    m_info2 = {14'h0, viol_cfg_ns, viol_nonsec, viol_master};
                end
                m_stat = 1'b1;
            end
            m_rdata = nrd;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R13 rdata vs model", rsp_rdata, m_rdata);
            for (int i = 0; i < NW; i++) check("R6 map word vs model", map[i*32 +: 32], m_map[i]);
            check("R12 irq vs model", {31'h0, irq}, {31'h0, m_stat & m_en});
            check("R12 irq_en vs model", {31'h0, irq_en}, {31'h0, m_en});
            check("R8 sec_resp vs model", {31'h0, sec_resp}, {31'h0, m_ctrl[4]});
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic access(input bit wr, input logic [9:0] a, input logic [3:0] s,
                          input logic [31:0] d, input bit sec, output logic [31:0] r);
        req_valid = 1'b1; req_write = wr; req_waddr = a; req_strb = s;
        req_wdata = d; req_secure = sec;
        @(negedge clk);
        r = rsp_rdata;
        req_valid = 1'b0; req_write = 1'b0; req_strb = '0; req_wdata = '0;
    endtask

    task automatic wr(input logic [9:0] a, input logic [3:0] s, input logic [31:0] d);
        logic [31:0] r;
        access(1'b1, a, s, d, 1'b1, r);
    endtask

    task automatic rd_chk(input string tag, input logic [9:0] a, input logic [3:0] s,
                          input bit sec, input logic [31:0] exp);
        logic [31:0] r;
        access(1'b0, a, s, 32'h0, sec, r);
        check(tag, r, exp);
    endtask

    task automatic viol_on(input logic [31:0] a, input logic [15:0] m, input bit ns, input bit c);
        viol_valid = 1'b1; viol_addr = a; viol_master = m; viol_nonsec = ns; viol_cfg_ns = c;
    endtask

    task automatic viol_off();
        viol_valid = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 ctrl reset", A_CTRL, 4'hF, 1'b1, 32'h0000_0100);
        rd_chk("R1 enable reset", A_EN, 4'hF, 1'b1, 32'h1);
        rd_chk("R1 pointer reset", A_PTR, 4'hF, 1'b1, 32'h0);
        rd_chk("R1 status reset", A_STAT, 4'hF, 1'b1, 32'h0);
        rd_chk("R1 info1 reset", A_INFO1, 4'hF, 1'b1, 32'h0);
        rd_chk("R1 info2 reset", A_INFO2, 4'hF, 1'b1, 32'h0);
        check("R1 map reset", map[31:0] | map[63:32] | map[159:128], 32'h0);

        // R8 constants and control mask
        rd_chk("R8 word count", A_COUNT, 4'hF, 1'b1, 32'h4);
        rd_chk("R8 block cfg", A_BCFG, 4'hF, 1'b1, 32'h7);
        wr(A_CTRL, 4'hF, 32'h7FFF_FFFF);
        rd_chk("R8 control mask", A_CTRL, 4'hF, 1'b1, 32'h0000_0110);
        check("R8 sec_resp out", {31'h0, sec_resp}, 32'h1);

        // R2 non-secure filtering and ID words
        rd_chk("R2 ns ctrl read", A_CTRL, 4'hF, 1'b0, 32'h0);
        begin
            logic [31:0] r;
            access(1'b1, A_PTR, 4'hF, 32'h3, 1'b0, r);
        end
        rd_chk("R2 ns write ignored", A_PTR, 4'hF, 1'b1, 32'h0);
        rd_chk("R2 ns id0", A_ID0, 4'hF, 1'b0, 32'h3C);
        rd_chk("R2 s id1", A_ID0 + 10'd1, 4'hF, 1'b1, 32'h2D);
        rd_chk("R2 s id11", A_ID0 + 10'd11, 4'hF, 1'b1, 32'h87);

        // R4 pointer modulo
        wr(A_PTR, 4'hF, 32'h7);
        rd_chk("R4 pointer 7 mod 5", A_PTR, 4'hF, 1'b1, 32'h2);
        wr(A_PTR, 4'hF, 32'h4);
        rd_chk("R4 pointer 4", A_PTR, 4'hF, 1'b1, 32'h4);

        // R3 stepping with wrap
        wr(A_PTR, 4'hF, 32'h3);
        wr(A_DATA, 4'hF, 32'h1111_1111);
        wr(A_DATA, 4'hF, 32'h2222_2222);
        wr(A_DATA, 4'hF, 32'h3333_3333);
        rd_chk("R3 pointer after wrap", A_PTR, 4'hF, 1'b1, 32'h1);
        check("R3 word3 written", map[3*32 +: 32], 32'h1111_1111);
        check("R3 word0 after wrap", map[31:0], 32'h3333_3333);
        rd_chk("R3 full read data", A_DATA, 4'hF, 1'b1, 32'h0);
        rd_chk("R3 read steps", A_PTR, 4'hF, 1'b1, 32'h2);
        wr(A_DATA, 4'h1, 32'h0000_00AB);
        rd_chk("R3 byte write no step", A_PTR, 4'hF, 1'b1, 32'h2);
        check("R6 byte into word2", map[2*32 +: 32], 32'h0000_00AB);

        // R6 merge vs zero fill
        wr(A_PTR, 4'hF, 32'h0);
        wr(A_DATA, 4'hC, 32'h5555_0000);
        check("R6 map halfword merge", map[31:0], 32'h5555_3333);
        rd_chk("R3 halfword no step", A_PTR, 4'hF, 1'b1, 32'h0);
        wr(A_CTRL, 4'h2, 32'h0);
        rd_chk("R6 ctrl byte merge", A_CTRL, 4'hF, 1'b1, 32'h0000_0010);
        wr(A_EN, 4'h2, 32'h0000_0100);
        rd_chk("R6 enable zero fill", A_EN, 4'hF, 1'b1, 32'h0);
        wr(A_EN, 4'hF, 32'h1);
        wr(A_PTR, 4'hF, 32'h2);
        wr(A_PTR, 4'h2, 32'h0000_0300);
        rd_chk("R6 pointer merge then mod", A_PTR, 4'hF, 1'b1, 32'h0);

        // R7 lane reads (stepping now off)
        rd_chk("R7 upper half", A_DATA, 4'hC, 1'b1, 32'h5555_0000);
        rd_chk("R7 lower half", A_DATA, 4'h3, 1'b1, 32'h0000_3333);
        rd_chk("R7 byte count", A_COUNT, 4'h1, 1'b1, 32'h4);
        rd_chk("R7 empty lane ctrl", A_CTRL, 4'h2, 1'b1, 32'h0);

        // R9 set / clear / write-only / ignored
        wr(A_SET, 4'hF, 32'h2);
        rd_chk("R9 set bit0 clear ignored", A_STAT, 4'hF, 1'b1, 32'h0);
        wr(A_SET, 4'hF, 32'h1);
        rd_chk("R9 set", A_STAT, 4'hF, 1'b1, 32'h1);
        check("R12 irq when set", {31'h0, irq}, 32'h1);
        rd_chk("R9 set reads zero", A_SET, 4'hF, 1'b1, 32'h0);
        rd_chk("R9 clr reads zero", A_CLR, 4'hF, 1'b1, 32'h0);
        wr(A_CLR, 4'hF, 32'h1);
        rd_chk("R9 clear", A_STAT, 4'hF, 1'b1, 32'h0);
        wr(A_ID0, 4'hF, 32'hFFFF_FFFF);
        rd_chk("R9 id write ignored", A_ID0, 4'hF, 1'b1, 32'h3C);
        wr(10'h010, 4'hF, 32'hFFFF_FFFF);
        rd_chk("R9 undefined reads zero", 10'h010, 4'hF, 1'b1, 32'h0);

        // R10 capture
        viol_on(32'h1234_5678, 16'hBEEF, 1'b1, 1'b0);
        @(negedge clk);
        viol_off();
        rd_chk("R10 status set", A_STAT, 4'hF, 1'b1, 32'h1);
        rd_chk("R10 info1", A_INFO1, 4'hF, 1'b1, 32'h1234_5678);
        rd_chk("R10 info2", A_INFO2, 4'hF, 1'b1, 32'h0001_BEEF);
        viol_on(32'hAAAA_0000, 16'h0001, 1'b0, 1'b1);
        @(negedge clk);
        viol_off();
        rd_chk("R10 second info1 kept", A_INFO1, 4'hF, 1'b1, 32'h1234_5678);

        // R11 capture beats clear
        viol_on(32'h0000_0C00, 16'h0042, 1'b0, 1'b1);
        wr(A_CLR, 4'hF, 32'h1);
        viol_off();
        rd_chk("R11 status kept", A_STAT, 4'hF, 1'b1, 32'h1);
        rd_chk("R11 info kept while set", A_INFO1, 4'hF, 1'b1, 32'h1234_5678);
        wr(A_CLR, 4'hF, 32'h1);
        viol_on(32'h0000_0D00, 16'h0043, 1'b0, 1'b1);
        wr(A_CLR, 4'hF, 32'h1);
        viol_off();
        rd_chk("R11 status after clear race", A_STAT, 4'hF, 1'b1, 32'h1);
        rd_chk("R11 fresh capture info2", A_INFO2, 4'hF, 1'b1, 32'h0002_0043);

        // R12 enable gating
        wr(A_EN, 4'hF, 32'h0);
        check("R12 irq masked", {31'h0, irq}, 32'h0);
        wr(A_EN, 4'hF, 32'h1);
        check("R12 irq unmasked", {31'h0, irq}, 32'h1);

        // R5 lockdown
        wr(A_CTRL, 4'hF, 32'h8000_0100);
        wr(A_CTRL, 4'hF, 32'h0);
        rd_chk("R5 ctrl frozen", A_CTRL, 4'hF, 1'b1, 32'h8000_0100);
        wr(A_PTR, 4'hF, 32'h1);
        wr(A_DATA, 4'hF, 32'hDEAD_BEEF);
        check("R5 map frozen", map[1*32 +: 32], 32'h0);
        rd_chk("R5 no step on blocked write", A_PTR, 4'hF, 1'b1, 32'h1);
        wr(A_EN, 4'hF, 32'h0);
        rd_chk("R5 enable frozen", A_EN, 4'hF, 1'b1, 32'h1);
        rd_chk("R5 read still steps", A_DATA, 4'hF, 1'b1, 32'h0);
        rd_chk("R5 pointer after read", A_PTR, 4'hF, 1'b1, 32'h2);

        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk("R5 reset releases lock", A_CTRL, 4'hF, 1'b1, 32'h0000_0100);
        rd_chk("R1 map cleared by reset", A_DATA, 4'hF, 1'b1, 32'h0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule